// File: doc/BRIEF.md
# PCM Time-Slot Alignment Port

This block terminates a serial PCM line carrying a 32-slot frame that repeats every 125 µs. It runs on a single master clock (8.192 MHz on the line, so 1024 clocks per frame) and an 8 kHz frame sync. Incoming bits are sampled at mid-bit and packed MSB first into 8-bit samples. Each sample comes out with its slot index and a one-cycle strobe. Outgoing samples are fetched one slot ahead through a load strobe and sent MSB first. The line runs either at single rate (8 bits of 4 clocks each per slot) or at double rate (16 bits of 2 clocks each per slot, of which only the first 8 carry data).

Where the line sits relative to sync is programmable, and receive and transmit are set separately. A bit offset shifts each direction by whole bit periods. A shared 5-bit slot delay shifts both directions by whole 32-clock slots. A launch-edge select picks the start or the middle of each bit period for outgoing data. A per-slot mode table marks every slot active, bypass or idle. Bypass loops the received sample back out, and idle sends all ones. This lets the stuffed slots of a 24-channel frame sit anywhere in the 32-slot frame, contiguous or not.

A two-state framing controller governs the port. After reset it is in `FT_HUNT`: it has no line timing, and all outputs stay quiet. On the first sync rising edge it takes the transition HUNT→RUN and enters `FT_RUN`. It then stays in RUN (transition RUN→RUN) and realigns its frame counter on every later sync edge. Only reset returns it to HUNT.

Top module: `pcm_slot_port`

## Requirements
- R1: After reset, and until the first sync rising edge, `rx_strobe` and `tx_load` stay 0, `tx_data` stays 1 and `sync_err` is 0. Reset also sets every slot's mode to active.
- R2: The frame counter is forced to 0 in the cycle after `fsync` is sampled rising and otherwise counts modulo 1024. In running state, any 1024-clock window with regular sync yields exactly 32 `rx_strobe` pulses, one for each slot index 0..31.
- R3: With `rate_dbl`=0, a slot holds 8 bits of 4 clocks each. `rx_in` is sampled in clock 2 (of 0..3) of each bit, the first bit is the MSB, and the byte appears on `rx_byte`/`rx_slot` with a one-cycle `rx_strobe`.
- R4: With `rate_dbl`=1, a slot holds 16 bits of 2 clocks each. `rx_in` is sampled in clock 1 of each bit, and only bits 0..7 of the slot form the byte.
- R5: Receive bit b of slot s is sampled when the counter equals ((s+`slot_dly`)·32 + (b+`rx_boff`)·C + M) mod 1024, where C is clocks per bit and M is the mid-bit clock. Transmit uses the same rule with `tx_boff`, so the two directions shift independently.
- R6: With `tx_edge`=0 a transmit bit is launched in clock 0 of its bit period, and with `tx_edge`=1 it is launched in the mid-bit clock. At double rate, bits 8..15 of every slot are sent as 1.
- R7: In transmit clock 1 of slot s, `tx_load` pulses for one cycle with `tx_ld_slot`=s+1 and `tx_byte` is captured in that cycle. The captured byte is sent MSB first in slot s+1.
- R8: Writing `mode_val`=0x02 to a slot puts it in bypass: the slot sends the latest byte received in that slot. Writing 0x01 makes the slot idle: it sends 0xFF and raises no `tx_load`. Any other value makes the slot active.
- R9: In running state, `sync_err` is set when sync rises at any count other than 1023, or when the count reaches 1023 without sync. Once set, it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst_n | input | 1 | asynchronous reset, active low |
| fsync | input | 1 | frame sync, rising edge marks frame start |
| rate_dbl | input | 1 | 0: 8-bit slots, 1: 16-bit slots |
| rx_boff | input | BOFF_W | receive bit offset in bit periods |
| tx_boff | input | BOFF_W | transmit bit offset in bit periods |
| slot_dly | input | 5 | slot delay for both directions |
| tx_edge | input | 1 | 0: launch at bit start, 1: launch at mid-bit |
| rx_in | input | 1 | serial receive data |
| tx_byte | input | 8 | outgoing sample for `tx_ld_slot` |
| mode_wr | input | 1 | mode table write enable |
| mode_slot | input | 5 | slot to write |
| mode_val | input | 8 | mode code: 0x02 bypass, 0x01 idle, other active |
| tx_data | output | 1 | serial transmit data |
| rx_strobe | output | 1 | received byte valid, one cycle |
| rx_slot | output | 5 | slot of the received byte |
| rx_byte | output | 8 | received byte |
| tx_load | output | 1 | outgoing byte captured this cycle |
| tx_ld_slot | output | 5 | slot whose outgoing byte is being fetched |
| sync_err | output | 1 | sticky frame sync error |

## Verification
Five line configurations are tried, each with its own byte pattern: single and double rate at zero alignment, then mixed receive and transmit offsets with small, large and wrapping slot delays and both launch edges. A misplaced offset, delay or edge moves the sampling or capture point and corrupts particular slots' bytes. Receive and transmit use different offsets and different data, so an offset applied to the wrong direction shows up as well. A mixed mode table with scattered bypass and idle slots, plus one unrecognised code, separates loopback, all-ones fill, the suppressed load strobe and the default. Early sync and missing sync are each driven from a locked state to separate the two error causes and to confirm that the flag stays set.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    localparam int CLK_PER_SLOT = 32;
    localparam int SAMPLE_W     = 8;

    localparam logic [7:0] MODE_CODE_BYPASS = 8'h02;
    localparam logic [7:0] MODE_CODE_IDLE   = 8'h01;

    typedef enum logic [1:0] {
        SM_ACTIVE = 2'd0,
        SM_BYPASS = 2'd1,
        SM_IDLE   = 2'd2
    } slot_mode_e;

    typedef enum logic {
        FT_HUNT = 1'b0,
        FT_RUN  = 1'b1
    } ft_state_e;

    function automatic slot_mode_e decode_mode(input logic [7:0] code);
        if (code == MODE_CODE_BYPASS)    return SM_BYPASS;
        else if (code == MODE_CODE_IDLE) return SM_IDLE;
        else                             return SM_ACTIVE;
    endfunction

endpackage

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer
    import pcm_port_pkg::*;
#(
    parameter  int SLOTS = 32,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int POS_W  = $clog2(CLK_PER_SLOT),
    localparam int CNT_W  = SLOT_W + POS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    output logic [CNT_W-1:0] cnt,
    output logic             run,
    output logic             sync_err
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOTS * CLK_PER_SLOT - 1);

    ft_state_e state_q, state_d;
    logic      fsync_q;
    logic      rise;

    assign rise = fsync & ~fsync_q;
    assign run  = (state_q == FT_RUN);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FT_HUNT: if (rise) state_d = FT_RUN;
            FT_RUN:  state_d = FT_RUN;
            default: state_d = FT_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FT_HUNT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsync_q  <= 1'b0;
            cnt      <= '0;
            sync_err <= 1'b0;
        end else begin
            fsync_q <= fsync;
            cnt     <= rise ? '0 : cnt + 1'b1;
            if (state_q == FT_RUN && ((rise && cnt != LAST) || (!rise && cnt == LAST)))
                sync_err <= 1'b1;
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |=> sync_err); // R9
    AST_EARLY_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (run && rise && cnt != LAST) |=> sync_err); // R9

endmodule

// File: rtl/pcm_slot_pos.sv
module pcm_slot_pos
    import pcm_port_pkg::*;
#(
    parameter  int SLOTS  = 32,
    parameter  int BOFF_W = 4,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int POS_W  = $clog2(CLK_PER_SLOT),
    localparam int CNT_W  = SLOT_W + POS_W
) (
    input  logic [CNT_W-1:0]  cnt,
    input  logic              dbl,
    input  logic [BOFF_W-1:0] boff,
    input  logic [SLOT_W-1:0] dly,
    output logic [SLOT_W-1:0] slot,
    output logic [POS_W-1:0]  pos,
    output logic [3:0]        bitn,
    output logic [1:0]        phase
);

    logic [CNT_W-1:0] boff_clk;
    logic [CNT_W-1:0] rel;

    assign boff_clk = dbl ? CNT_W'({boff, 1'b0}) : CNT_W'({boff, 2'b00});
    assign rel      = cnt - boff_clk - {dly, {POS_W{1'b0}}};
    assign slot     = rel[CNT_W-1:POS_W];
    assign pos      = rel[POS_W-1:0];
    assign bitn     = dbl ? pos[4:1] : {1'b0, pos[4:2]};
    assign phase    = dbl ? {1'b0, pos[0]} : pos[1:0];

endmodule

// File: rtl/pcm_rx_deframer.sv
module pcm_rx_deframer
    import pcm_port_pkg::*;
#(
    parameter  int SLOTS  = 32,
    parameter  int BOFF_W = 4,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int POS_W  = $clog2(CLK_PER_SLOT),
    localparam int CNT_W  = SLOT_W + POS_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic [CNT_W-1:0]    cnt,
    input  logic                dbl,
    input  logic [BOFF_W-1:0]   boff,
    input  logic [SLOT_W-1:0]   dly,
    input  logic                rx_in,
    output logic                rx_strobe,
    output logic [SLOT_W-1:0]   rx_slot,
    output logic [SAMPLE_W-1:0] rx_byte
);

    logic [SLOT_W-1:0]   slot;
    logic [POS_W-1:0]    pos;
    logic [3:0]          bitn;
    logic [1:0]          phase;
    logic                mid, take;
    logic [SAMPLE_W-1:0] sr;

    pcm_slot_pos #(.SLOTS(SLOTS), .BOFF_W(BOFF_W)) u_pos (
        .cnt(cnt), .dbl(dbl), .boff(boff), .dly(dly),
        .slot(slot), .pos(pos), .bitn(bitn), .phase(phase)
    );

    assign mid  = dbl ? (phase == 2'd1) : (phase == 2'd2);
    assign take = run && mid && !bitn[3];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr        <= '0;
            rx_strobe <= 1'b0;
            rx_slot   <= '0;
            rx_byte   <= '0;
        end else begin
            rx_strobe <= take && (bitn[2:0] == 3'd7);
            if (take) sr <= {sr[SAMPLE_W-2:0], rx_in};
            if (take && bitn[2:0] == 3'd7) begin
                rx_byte <= {sr[SAMPLE_W-2:0], rx_in};
                rx_slot <= slot;
            end
        end
    end

    AST_HUNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |-> $past(run)); // R1
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |=> !rx_strobe); // R2

endmodule

// File: rtl/pcm_tx_framer.sv
module pcm_tx_framer
    import pcm_port_pkg::*;
#(
    parameter  int SLOTS  = 32,
    parameter  int BOFF_W = 4,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int POS_W  = $clog2(CLK_PER_SLOT),
    localparam int CNT_W  = SLOT_W + POS_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic [CNT_W-1:0]    cnt,
    input  logic                dbl,
    input  logic                edge_sel,
    input  logic [BOFF_W-1:0]   boff,
    input  logic [SLOT_W-1:0]   dly,
    input  slot_mode_e          ld_mode,
    input  logic [SAMPLE_W-1:0] hist_byte,
    input  logic [SAMPLE_W-1:0] tx_byte,
    output logic                tx_data,
    output logic                tx_load,
    output logic [SLOT_W-1:0]   tx_ld_slot
);

    logic [SLOT_W-1:0]   slot;
    logic [POS_W-1:0]    pos;
    logic [3:0]          bitn;
    logic [1:0]          phase;
    logic [1:0]          launch_ph;
    logic                launch, slot_start, ld_pend;
    logic [SAMPLE_W-1:0] pending, cur, cbyte;

    pcm_slot_pos #(.SLOTS(SLOTS), .BOFF_W(BOFF_W)) u_pos (
        .cnt(cnt), .dbl(dbl), .boff(boff), .dly(dly),
        .slot(slot), .pos(pos), .bitn(bitn), .phase(phase)
    );

    assign launch_ph  = edge_sel ? (dbl ? 2'd1 : 2'd2) : 2'd0;
    assign launch     = run && (phase == launch_ph);
    assign slot_start = run && (pos == '0);
    assign cbyte      = (pos == '0) ? pending : cur;
    assign tx_load    = ld_pend && (ld_mode == SM_ACTIVE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld_pend    <= 1'b0;
            tx_ld_slot <= '0;
            pending    <= '1;
            cur        <= '1;
            tx_data    <= 1'b1;
        end else begin
            ld_pend <= slot_start;
            if (slot_start) begin
                tx_ld_slot <= slot + 1'b1;
                cur        <= pending;
            end
            if (ld_pend) begin
                unique case (ld_mode)
                    SM_ACTIVE: pending <= tx_byte;
                    SM_BYPASS: pending <= hist_byte;
                    SM_IDLE:   pending <= '1;
                    default:   pending <= '1;
                endcase
            end
            if (!run)
                tx_data <= 1'b1;
            else if (launch)
                tx_data <= bitn[3] ? 1'b1 : cbyte[3'd7 - bitn[2:0]];
        end
    end

    AST_TX_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && bitn[3]) |=> tx_data); // R6
    AST_TX_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> tx_data); // R1
    AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> !tx_load); // R7

endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port
    import pcm_port_pkg::*;
#(
    parameter  int SLOTS  = 32,
    parameter  int BOFF_W = 4,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int POS_W  = $clog2(CLK_PER_SLOT),
    localparam int CNT_W  = SLOT_W + POS_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fsync,
    input  logic                rate_dbl,
    input  logic [BOFF_W-1:0]   rx_boff,
    input  logic [BOFF_W-1:0]   tx_boff,
    input  logic [SLOT_W-1:0]   slot_dly,
    input  logic                tx_edge,
    input  logic                rx_in,
    input  logic [SAMPLE_W-1:0] tx_byte,
    input  logic                mode_wr,
    input  logic [SLOT_W-1:0]   mode_slot,
    input  logic [7:0]          mode_val,
    output logic                tx_data,
    output logic                rx_strobe,
    output logic [SLOT_W-1:0]   rx_slot,
    output logic [SAMPLE_W-1:0] rx_byte,
    output logic                tx_load,
    output logic [SLOT_W-1:0]   tx_ld_slot,
    output logic                sync_err
);

    logic [CNT_W-1:0]    cnt;
    logic                run;
    slot_mode_e          mode_tab [SLOTS];
    logic [SAMPLE_W-1:0] rx_hist  [SLOTS];

    pcm_frame_timer #(.SLOTS(SLOTS)) u_timer (
        .clk(clk), .rst_n(rst_n), .fsync(fsync),
        .cnt(cnt), .run(run), .sync_err(sync_err)
    );

    pcm_rx_deframer #(.SLOTS(SLOTS), .BOFF_W(BOFF_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .run(run), .cnt(cnt),
        .dbl(rate_dbl), .boff(rx_boff), .dly(slot_dly), .rx_in(rx_in),
        .rx_strobe(rx_strobe), .rx_slot(rx_slot), .rx_byte(rx_byte)
    );

    pcm_tx_framer #(.SLOTS(SLOTS), .BOFF_W(BOFF_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .run(run), .cnt(cnt),
        .dbl(rate_dbl), .edge_sel(tx_edge), .boff(tx_boff), .dly(slot_dly),
        .ld_mode(mode_tab[tx_ld_slot]), .hist_byte(rx_hist[tx_ld_slot]),
        .tx_byte(tx_byte), .tx_data(tx_data), .tx_load(tx_load),
        .tx_ld_slot(tx_ld_slot)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) begin
                mode_tab[i] <= SM_ACTIVE;
                rx_hist[i]  <= '0;
            end
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                if (mode_wr && mode_slot == SLOT_W'(i))
                    mode_tab[i] <= decode_mode(mode_val);
                if (rx_strobe && rx_slot == SLOT_W'(i))
                    rx_hist[i] <= rx_byte;
            end
        end
    end

    AST_IDLE_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> (mode_tab[tx_ld_slot] != SM_IDLE)); // R8

endmodule

// File: tb/test_pcm_slot_port.sv
module test_pcm_slot_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fsync = 1'b0;
    logic       rate_dbl = 1'b0;
    logic [3:0] rx_boff = '0, tx_boff = '0;
    logic [4:0] slot_dly = '0;
    logic       tx_edge = 1'b0;
    logic       rx_in = 1'b0;
    logic [7:0] tx_byte;
    logic       mode_wr = 1'b0;
    logic [4:0] mode_slot = '0;
    logic [7:0] mode_val = '0;
    logic       tx_data, rx_strobe, tx_load, sync_err;
    logic [4:0] rx_slot, tx_ld_slot;
    logic [7:0] rx_byte;

    int checks = 0, fails = 0, seed = 0;

    pcm_slot_port i_pcm_slot_port (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .rate_dbl(rate_dbl),
        .rx_boff(rx_boff), .tx_boff(tx_boff), .slot_dly(slot_dly), .tx_edge(tx_edge),
        .rx_in(rx_in), .tx_byte(tx_byte), .mode_wr(mode_wr), .mode_slot(mode_slot),
        .mode_val(mode_val), .tx_data(tx_data), .rx_strobe(rx_strobe), .rx_slot(rx_slot),
        .rx_byte(rx_byte), .tx_load(tx_load), .tx_ld_slot(tx_ld_slot), .sync_err(sync_err)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] rx_pat(input int s, input int sd);
        return 8'((s * 29) + (sd * 71) + 60);
    endfunction
    function automatic logic [7:0] tx_pat(input int s, input int sd);
        return 8'((s * 53) ^ (sd * 17) ^ 165);
    endfunction

    assign tx_byte = tx_pat(int'(tx_ld_slot), seed);

    // {rate_dbl, rx_boff, tx_boff, slot_dly, tx_edge, seed}; 32 strobes expected per frame
    localparam logic [18:0] VEC [5] = '{
        {1'b0, 4'd0,  4'd0,  5'd0,  1'b0, 4'd1},
        {1'b1, 4'd0,  4'd0,  5'd0,  1'b0, 4'd2},
        {1'b0, 4'd3,  4'd5,  5'd7,  1'b1, 4'd3},
        {1'b1, 4'd9,  4'd2,  5'd31, 1'b1, 4'd4},
        {1'b0, 4'd15, 4'd15, 5'd1,  1'b0, 4'd5}
    };

    // line model state
    bit         line_on = 0, sync_en = 1, early_req = 0;
    int         bc = 0, sc = 1023;
    logic [7:0] rx_got [32], tx_got [32];
    int         rx_seen [32], tx_bits [32], load_cnt [32];
    int         rx_total = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic void locate(input int c, input logic d, input int off, input int dl,
                                   output int sl, output int bt, output int ph);
        int r, p;
        r  = (((c - off * (d ? 2 : 4) - dl * 32) % 1024) + 1024) % 1024;
        sl = r / 32;
        p  = r % 32;
        bt = d ? p / 2 : p / 4;
        ph = d ? p % 2 : p % 4;
    endfunction

    task automatic clear_caps();
        for (int s = 0; s < 32; s++) begin
            rx_got[s] = '0; tx_got[s] = '0;
            rx_seen[s] = 0; tx_bits[s] = 0; load_cnt[s] = 0;
        end
        rx_total = 0;
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (line_on) begin
                int sl, bt, ph, lp;
                logic [7:0] b;
                if (rx_strobe) begin
                    rx_got[rx_slot] = rx_byte;
                    rx_seen[rx_slot]++;
                    rx_total++;
                end
                if (tx_load) load_cnt[tx_ld_slot]++;
                locate(bc - 1, rate_dbl, int'(tx_boff), int'(slot_dly), sl, bt, ph);
                lp = tx_edge ? (rate_dbl ? 1 : 2) : 0;
                if (ph == lp && bt < 8) begin
                    tx_got[sl][7 - bt] = tx_data;
                    tx_bits[sl]++;
                end
                locate(bc, rate_dbl, int'(rx_boff), int'(slot_dly), sl, bt, ph);
                b = rx_pat(sl, seed);
                rx_in = (bt < 8) ? b[7 - bt] : 1'b0;
                if (early_req) begin
                    sc = 1023;
                    early_req = 0;
                end
                fsync = sync_en && (sc == 1023);
                sc = (sc == 1023) ? 0 : sc + 1;
                bc = fsync ? 0 : (bc + 1) % 1024;
            end
        end
    end

    initial begin
        #3000000;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_mode(input int s, input logic [7:0] v);
        mode_slot = 5'(s); mode_val = v; mode_wr = 1'b1;
        cycles(1);
        mode_wr = 1'b0;
    endtask

    task automatic check_window(input string rxreq, input string txreq);
        int bad_rx, bad_tx, bad_ld;
        bad_rx = 0; bad_tx = 0; bad_ld = 0;
        chk(rx_total == 32, "R2", "strobes per frame", rx_total, 32);
        for (int s = 0; s < 32; s++) begin
            if (rx_seen[s] != 1 || rx_got[s] != rx_pat(s, seed)) begin
                bad_rx++;
                chk(0, rxreq, $sformatf("rx slot %0d", s), int'(rx_got[s]), int'(rx_pat(s, seed)));
            end
            if (tx_bits[s] != 8 || tx_got[s] != tx_pat(s, seed)) begin
                bad_tx++;
                chk(0, txreq, $sformatf("tx slot %0d", s), int'(tx_got[s]), int'(tx_pat(s, seed)));
            end
            if (load_cnt[s] != 1) bad_ld++;
        end
        chk(bad_rx == 0, rxreq, "rx bytes wrong", bad_rx, 0);
        chk(bad_tx == 0, txreq, "tx bytes wrong", bad_tx, 0);
        chk(bad_ld == 0, "R7", "slots without single load", bad_ld, 0);
    endtask

    initial begin
        int noisy;
        cycles(5);
        rst_n = 1'b1;
        cycles(1);
        chk(rx_strobe == 0 && tx_load == 0, "R1", "strobes after reset", int'({rx_strobe, tx_load}), 0);
        chk(tx_data == 1, "R1", "tx_data after reset", int'(tx_data), 1);
        chk(sync_err == 0, "R1", "sync_err after reset", int'(sync_err), 0);
        noisy = 0;
        for (int i = 0; i < 2000; i++) begin
            cycles(1);
            if (rx_strobe || tx_load || !tx_data || sync_err) noisy++;
        end
        chk(noisy == 0, "R1", "activity before first sync", noisy, 0);

        // table of line configurations
        for (int v = 0; v < 5; v++) begin
            {rate_dbl, rx_boff, tx_boff, slot_dly, tx_edge} = VEC[v][18:4];
            seed    = int'(VEC[v][3:0]);
            line_on = 1;
            cycles(2048);
            clear_caps();
            cycles(1024);
            check_window(rate_dbl ? "R4 R5" : "R3 R5", tx_edge ? "R6 R5" : "R7 R5");
        end
        chk(sync_err == 0, "R9", "sync_err with regular sync", int'(sync_err), 0);

        // mode table: scattered bypass and idle slots
        {rate_dbl, rx_boff, tx_boff, slot_dly, tx_edge} = {1'b0, 4'd2, 4'd6, 5'd3, 1'b1};
        seed = 9;
        write_mode(3, 8'h02);
        write_mode(20, 8'h02);
        write_mode(10, 8'h01);
        write_mode(27, 8'h01);
        write_mode(5, 8'h05);
        cycles(3072);
        clear_caps();
        cycles(1024);
        chk(tx_got[3] == rx_pat(3, seed), "R8", "bypass slot 3", int'(tx_got[3]), int'(rx_pat(3, seed)));
        chk(tx_got[20] == rx_pat(20, seed), "R8", "bypass slot 20", int'(tx_got[20]), int'(rx_pat(20, seed)));
        chk(tx_got[10] == 8'hFF, "R8", "idle slot 10", int'(tx_got[10]), 255);
        chk(tx_got[27] == 8'hFF, "R8", "idle slot 27", int'(tx_got[27]), 255);
        chk(load_cnt[10] == 0 && load_cnt[27] == 0, "R8", "load on idle slot",
            load_cnt[10] + load_cnt[27], 0);
        chk(tx_got[5] == tx_pat(5, seed), "R8", "other code stays active", int'(tx_got[5]), int'(tx_pat(5, seed)));
        chk(tx_got[12] == tx_pat(12, seed), "R7", "active slot 12", int'(tx_got[12]), int'(tx_pat(12, seed)));

        // early sync
        cycles(300);
        chk(sync_err == 0, "R9", "sync_err before early sync", int'(sync_err), 0);
        early_req = 1;
        cycles(20);
        chk(sync_err == 1, "R9", "early sync flagged", int'(sync_err), 1);
        cycles(2100);
        chk(sync_err == 1, "R9", "flag sticky", int'(sync_err), 1);

        // reset clears, relock, then missing sync
        rst_n = 1'b0;
        cycles(3);
        chk(sync_err == 0 && rx_strobe == 0, "R1", "reset clears flag", int'(sync_err), 0);
        rst_n = 1'b1;
        cycles(2100);
        chk(sync_err == 0, "R9", "relocked without error", int'(sync_err), 0);
        sync_en = 0;
        cycles(1100);
        chk(sync_err == 1, "R9", "missing sync flagged", int'(sync_err), 1);
        sync_en = 1;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule